// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block receives configuration frames over a three-wire serial port (serial clock, serial data, latch enable) and holds two configuration registers for a frequency synthesizer core. All three wires are brought into the core clock domain through a synchronizer chain. Each rising edge of the synchronized serial clock shifts one data bit into an 18-bit frame register, most significant bit first. The last bit shifted in is the address. A rising edge of the synchronized latch enable copies the 17 bits above the address into either the reference-divider register or the feedback-divider register. Both registers stay in use while they are decoded into separate fields for the divider and phase-detector logic.

Loading works the same whatever the stored power-down and counter-reset fields hold. The serial port therefore stays usable in every power-saving state of the surrounding synthesizer. A latch pulse transfers whatever the frame register currently holds. A short frame mixes older bits with new ones, and a long frame keeps only its last 18 bits.

Top module: `serial_cfg_loader`

## Requirements
- R1: While rst_ni is low, every decoded output is zero.
- R2: Each rising edge of sclk_i shifts sdata_i into the frame register. Shifting is MSB first, so the bit sent last becomes frame bit 0. A falling edge of sclk_i changes nothing.
- R3: A latch with frame bit 0 equal to 1 loads the reference register from frame bits 14:1. The fields are: divide value in frame bits 10:1, charge-pump disable in bit 11, detector polarity in bit 12, reserved bit in bit 13, test-mode select in bit 14. Frame bits 17:15 are discarded.
- R4: A latch with frame bit 0 equal to 0 loads the feedback register from frame bits 17:1. The fields are: power-down in bit 1, counter reset in bit 2, swallow count in bits 7:3, program count in bits 17:8.
- R5: A latch to one register leaves every field of the other register unchanged.
- R6: The outputs change only on a rising edge of le_i. Serial clocks shifted while le_i is held high, and the falling edge of le_i, leave them unchanged.
- R7: A latch transfers the current frame register contents whatever number of bits came since the last latch. A short frame keeps the older bits in the upper positions. A long frame keeps only its last 18 bits.
- R8: With SYNC_STAGES = S, le_i high at clock edge k and low at edge k-1 updates the outputs at edge k+S. With sclk_i, the shift of the frame register happens at the same edge.
- R9: Loading keeps working after power-down and counter reset are both stored as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, asynchronous |
| le_i | input | 1 | Latch enable, asynchronous |
| ref_div_o | output | 10 | Reference divide value |
| cp_tri_o | output | 1 | Charge-pump output disable |
| pd_pol_o | output | 1 | Phase-detector polarity |
| ref_rsvd_o | output | 1 | Reserved reference bit as written |
| test_mode_o | output | 1 | Divider-output test mode select |
| pwdn_o | output | 1 | Power-down request |
| cnt_rst_o | output | 1 | Counter reset request |
| swallow_o | output | 5 | Swallow (dual-modulus) count |
| prog_cnt_o | output | 10 | Programmable main count |

## Verification
The bench sends frames to both addresses with asymmetric field values. A design that shifted LSB first, or took a field one bit off, would show scrambled divide values. It also checks the untouched register after each write, which catches a decoder that writes both registers or ignores the address bit. Short and long frames check that the frame register is never cleared by a latch and never holds more than 18 bits. Serial clocks sent while latch enable is held high, followed by the latch falling edge, expose a level-sensitive or falling-edge latch. A latency probe around the latch edge, and loads made after both power-down fields are set, catch an extra or missing pipeline stage and a port locked by power-down.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;
  localparam int unsigned FRAME_W = 18;
  localparam int unsigned DATA_W  = FRAME_W - 1;
  localparam int unsigned RDIV_W  = 10;
  localparam int unsigned ACNT_W  = 5;
  localparam int unsigned BCNT_W  = 10;
  localparam int unsigned REF_W   = RDIV_W + 4;

  // field order follows data bit positions, MSB first
  typedef struct packed {
    logic              test_mode;
    logic              rsvd;
    logic              pd_pol;
    logic              cp_tri;
    logic [RDIV_W-1:0] div;
  } ref_cfg_t;

  typedef struct packed {
    logic [BCNT_W-1:0] prog;
    logic [ACNT_W-1:0] swallow;
    logic              cnt_rst;
    logic              pwdn;
  } fb_cfg_t;
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  if (STAGES == 0) begin : g_bypass
    assign q_o = d_i;
  end else begin : g_chain
    logic [WIDTH-1:0] stg_q [STAGES];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      end else begin
        stg_q[0] <= d_i;
        for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
    end
    assign q_o = stg_q[STAGES-1];
  end
endmodule

// File: rtl/scl_rise_det.sv
module scl_rise_det #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= d_i;
  end
  assign rise_o = d_i & ~prev_q;
endmodule

// File: rtl/scl_shifter.sv
module scl_shifter
  import serial_cfg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               shift_en_i,
  input  logic               bit_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [FRAME_W-1:0] frame_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         frame_q <= '0;
    else if (shift_en_i) frame_q <= {frame_q[FRAME_W-2:0], bit_i};
  end
  assign frame_o = frame_q;
endmodule

// File: rtl/scl_reg_bank.sv
module scl_reg_bank
  import serial_cfg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               latch_i,
  input  logic [FRAME_W-1:0] frame_i,
  output ref_cfg_t           ref_o,
  output fb_cfg_t            fb_o
);
  logic     sel_ref;
  ref_cfg_t ref_q;
  fb_cfg_t  fb_q;

  assign sel_ref = frame_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ref_q <= '0;
    else if (latch_i && sel_ref) ref_q <= ref_cfg_t'(frame_i[REF_W:1]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  fb_q <= '0;
    else if (latch_i && !sel_ref) fb_q <= fb_cfg_t'(frame_i[FRAME_W-1:1]);
  end

  assign ref_o = ref_q;
  assign fb_o  = fb_q;
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import serial_cfg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              le_i,
  output logic [RDIV_W-1:0] ref_div_o,
  output logic              cp_tri_o,
  output logic              pd_pol_o,
  output logic              ref_rsvd_o,
  output logic              test_mode_o,
  output logic              pwdn_o,
  output logic              cnt_rst_o,
  output logic [ACNT_W-1:0] swallow_o,
  output logic [BCNT_W-1:0] prog_cnt_o
);
  logic [2:0]         pins_s;
  logic               sclk_s, dat_s, le_s;
  logic [1:0]         rise;
  logic               sclk_rise, le_rise;
  logic [FRAME_W-1:0] shift_q;
  ref_cfg_t           ref_cfg;
  fb_cfg_t            fb_cfg;

  // data shares the clock's chain depth so the two stay aligned
  scl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({le_i, sdata_i, sclk_i}),
    .q_o    (pins_s)
  );
  assign {le_s, dat_s, sclk_s} = pins_s;

  scl_rise_det #(.WIDTH(2)) u_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({le_s, sclk_s}),
    .rise_o (rise)
  );
  assign {le_rise, sclk_rise} = rise;

  scl_shifter u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (sclk_rise),
    .bit_i      (dat_s),
    .frame_o    (shift_q)
  );

  scl_reg_bank u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .latch_i (le_rise),
    .frame_i (shift_q),
    .ref_o   (ref_cfg),
    .fb_o    (fb_cfg)
  );

  assign ref_div_o   = ref_cfg.div;
  assign cp_tri_o    = ref_cfg.cp_tri;
  assign pd_pol_o    = ref_cfg.pd_pol;
  assign ref_rsvd_o  = ref_cfg.rsvd;
  assign test_mode_o = ref_cfg.test_mode;
  assign pwdn_o      = fb_cfg.pwdn;
  assign cnt_rst_o   = fb_cfg.cnt_rst;
  assign swallow_o   = fb_cfg.swallow;
  assign prog_cnt_o  = fb_cfg.prog;
endmodule

// File: rtl/serial_cfg_loader_chk.sv
module serial_cfg_loader_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sclk_rise,
  input logic        le_rise,
  input logic        dat_s,
  input logic [17:0] shift_q,
  input logic [9:0]  ref_div_o,
  input logic        cp_tri_o,
  input logic        pd_pol_o,
  input logic        ref_rsvd_o,
  input logic        test_mode_o,
  input logic        pwdn_o,
  input logic        cnt_rst_o,
  input logic [4:0]  swallow_o,
  input logic [9:0]  prog_cnt_o
);
  logic [13:0] ref_v;
  logic [16:0] fb_v;
  assign ref_v = {test_mode_o, ref_rsvd_o, pd_pol_o, cp_tri_o, ref_div_o};
  assign fb_v  = {prog_cnt_o, swallow_o, cnt_rst_o, pwdn_o};

  assert_shift_in_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_rise |=> shift_q == $past({shift_q[16:0], dat_s}));

  assert_shift_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_rise |=> $stable(shift_q));

  assert_ref_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_rise && shift_q[0]) |=> ref_v == $past(shift_q[14:1]));

  assert_fb_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_rise && !shift_q[0]) |=> fb_v == $past(shift_q[17:1]));

  assert_fb_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_rise && shift_q[0]) |=> $stable(fb_v));

  assert_ref_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_rise && !shift_q[0]) |=> $stable(ref_v));

  assert_no_latch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !le_rise |=> ($stable(ref_v) && $stable(fb_v)));
endmodule

bind serial_cfg_loader serial_cfg_loader_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sclk_rise   (sclk_rise),
  .le_rise     (le_rise),
  .dat_s       (dat_s),
  .shift_q     (shift_q),
  .ref_div_o   (ref_div_o),
  .cp_tri_o    (cp_tri_o),
  .pd_pol_o    (pd_pol_o),
  .ref_rsvd_o  (ref_rsvd_o),
  .test_mode_o (test_mode_o),
  .pwdn_o      (pwdn_o),
  .cnt_rst_o   (cnt_rst_o),
  .swallow_o   (swallow_o),
  .prog_cnt_o  (prog_cnt_o)
);

// File: tb/serial_cfg_loader_test.sv
module serial_cfg_loader_test;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;
  localparam int HOLD = SYNC + 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk_i = 1'b0, sdata_i = 1'b0, le_i = 1'b0;
  logic [9:0] ref_div_o, prog_cnt_o;
  logic cp_tri_o, pd_pol_o, ref_rsvd_o, test_mode_o, pwdn_o, cnt_rst_o;
  logic [4:0] swallow_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  serial_cfg_loader #(.SYNC_STAGES(SYNC)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .sdata_i(sdata_i), .le_i(le_i),
    .ref_div_o(ref_div_o), .cp_tri_o(cp_tri_o), .pd_pol_o(pd_pol_o),
    .ref_rsvd_o(ref_rsvd_o), .test_mode_o(test_mode_o), .pwdn_o(pwdn_o),
    .cnt_rst_o(cnt_rst_o), .swallow_o(swallow_o), .prog_cnt_o(prog_cnt_o)
  );

  function automatic logic [13:0] ref_now();
    return {test_mode_o, ref_rsvd_o, pd_pol_o, cp_tri_o, ref_div_o};
  endfunction
  function automatic logic [16:0] fb_now();
    return {prog_cnt_o, swallow_o, cnt_rst_o, pwdn_o};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference: delayed pin samples in a queue
  logic [2:0]  pin_q [$];
  logic [17:0] m_shift;
  logic [13:0] m_ref;
  logic [16:0] m_fb;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q.delete();
      m_shift = '0; m_ref = '0; m_fb = '0;
    end else begin
      pin_q.push_back({le_i, sdata_i, sclk_i});
      if (pin_q.size() > SYNC + 2) void'(pin_q.pop_front());
      if (pin_q.size() == SYNC + 2) begin
        logic [2:0] cur, prv;
        cur = pin_q[1];
        prv = pin_q[0];
        if (cur[2] && !prv[2]) begin
          if (m_shift[0]) m_ref = m_shift[14:1];
          else            m_fb  = m_shift[17:1];
        end
        if (cur[0] && !prv[0]) m_shift = {m_shift[16:0], cur[1]};
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R6 model ref", 32'(ref_now()), 32'(m_ref));
      chk("R6 model fb", 32'(fb_now()), 32'(m_fb));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic shift_bits(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata_i = bits[i];
      idle(HOLD);
      sclk_i = 1'b1;
      idle(HOLD);
      sclk_i = 1'b0;
    end
    idle(HOLD);
  endtask

  task automatic pulse_le();
    le_i = 1'b1;
    idle(HOLD);
    le_i = 1'b0;
    idle(HOLD + SYNC + 2);
  endtask

  function automatic logic [17:0] ref_frame(input logic [9:0] div, input logic cp,
      input logic pol, input logic rsvd, input logic tst, input logic [2:0] junk);
    return {junk, tst, rsvd, pol, cp, div, 1'b1};
  endfunction

  function automatic logic [17:0] fb_frame(input logic [9:0] b, input logic [4:0] a,
      input logic crst, input logic pd);
    return {b, a, crst, pd, 1'b0};
  endfunction

  initial begin
    logic [17:0] f, g;
    logic [13:0] ref_keep;
    logic [16:0] fb_keep;
    idle(3);
    chk("R1 reset ref", 32'(ref_now()), 32'h0);
    chk("R1 reset fb", 32'(fb_now()), 32'h0);
    rst_ni = 1'b1;
    idle(HOLD);

    // R3 / R2: reference frame, asymmetric fields, junk in upper bits
    shift_bits(32'(ref_frame(10'h2A5, 1'b1, 1'b0, 1'b1, 1'b1, 3'b101)), 18);
    pulse_le();
    chk("R2 msb first div", 32'(ref_div_o), 32'h2A5);
    chk("R3 cp_tri", 32'(cp_tri_o), 32'h1);
    chk("R3 pd_pol", 32'(pd_pol_o), 32'h0);
    chk("R3 rsvd", 32'(ref_rsvd_o), 32'h1);
    chk("R3 test", 32'(test_mode_o), 32'h1);
    chk("R5 fb untouched", 32'(fb_now()), 32'h0);

    // R4: feedback frame
    shift_bits(32'(fb_frame(10'h3C1, 5'h16, 1'b0, 1'b1)), 18);
    pulse_le();
    chk("R4 prog", 32'(prog_cnt_o), 32'h3C1);
    chk("R4 swallow", 32'(swallow_o), 32'h16);
    chk("R4 cnt_rst", 32'(cnt_rst_o), 32'h0);
    chk("R4 pwdn", 32'(pwdn_o), 32'h1);
    chk("R5 ref untouched", 32'(ref_now()), 32'(ref_frame(10'h2A5, 1'b1, 1'b0, 1'b1, 1'b1, 3'b0) >> 1));

    // R3 boundary values
    shift_bits(32'(ref_frame(10'h3FF, 1'b0, 1'b1, 1'b0, 1'b0, 3'b111)), 18);
    pulse_le();
    chk("R3 div max", 32'(ref_div_o), 32'h3FF);
    chk("R3 pol set", 32'(pd_pol_o), 32'h1);
    chk("R3 test clr", 32'(test_mode_o), 32'h0);

    // R6: clocks with LE held high, then its falling edge
    ref_keep = ref_now();
    fb_keep  = fb_now();
    le_i = 1'b1;
    idle(HOLD + SYNC + 2);
    ref_keep = ref_now();
    shift_bits(32'(ref_frame(10'h002, 1'b0, 1'b0, 1'b0, 1'b0, 3'b0)), 18);
    chk("R6 ref while le high", 32'(ref_now()), 32'(ref_keep));
    le_i = 1'b0;
    idle(HOLD + SYNC + 2);
    chk("R6 ref after le fall", 32'(ref_now()), 32'(ref_keep));
    chk("R6 fb after le fall", 32'(fb_now()), 32'(fb_keep));
    pulse_le();
    chk("R6 div min on rise", 32'(ref_div_o), 32'h002);

    // R7: short frame keeps older bits
    f = fb_frame(10'h155, 5'h1F, 1'b0, 1'b0);
    shift_bits(32'(f), 18);
    pulse_le();
    chk("R7 full fb swallow max", 32'(swallow_o), 32'h1F);
    shift_bits(32'h13, 5);
    pulse_le();
    g = {f[12:0], 5'b10011};
    chk("R7 short frame ref", 32'(ref_now()), 32'(g[14:1]));

    // R7: long frame keeps last 18 bits
    f = fb_frame(10'h0A3, 5'h05, 1'b1, 1'b0);
    shift_bits({10'h0, 4'b1011, f}, 22);
    pulse_le();
    chk("R7 long frame fb", 32'(fb_now()), 32'(f[17:1]));

    // R8: latency from LE rise
    shift_bits(32'(ref_frame(10'h0F0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b0)), 18);
    ref_keep = ref_now();
    le_i = 1'b1;
    @(posedge clk_i);
    repeat (SYNC - 1) @(posedge clk_i);
    @(negedge clk_i);
    chk("R8 not yet", 32'(ref_now()), 32'(ref_keep));
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R8 updated", 32'(ref_div_o), 32'h0F0);
    idle(HOLD);
    le_i = 1'b0;
    idle(HOLD + SYNC + 2);

    // R9: loads after power-down and counter reset both stored
    shift_bits(32'(fb_frame(10'h200, 5'h01, 1'b1, 1'b1)), 18);
    pulse_le();
    chk("R9 pwdn set", 32'(pwdn_o), 32'h1);
    chk("R9 cnt_rst set", 32'(cnt_rst_o), 32'h1);
    shift_bits(32'(ref_frame(10'h1E7, 1'b1, 1'b1, 1'b0, 1'b0, 3'b0)), 18);
    pulse_le();
    chk("R9 ref loads in power-down", 32'(ref_div_o), 32'h1E7);
    shift_bits(32'(fb_frame(10'h003, 5'h00, 1'b0, 1'b0)), 18);
    pulse_le();
    chk("R9 fb reload", 32'(fb_now()), 32'(fb_frame(10'h003, 5'h00, 1'b0, 1'b0) >> 1));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule